// File: doc/BRIEF.md
# Multi-Mode Pixel Colour Processor

This block sits between a video-memory fetch engine and a display output. It receives 32-bit words of raw pixel data on a valid/ready stream and produces one 24-bit RGB value per pixel on a second valid/ready stream. A three-bit format selector sets how each word is cut into pixels and how each pixel becomes RGB. Two formats carry full colour (32-bit with an unused byte, and tightly packed 24-bit). One is 16-bit 5-6-5. The last two are 8-bit: one is a grey level and one is an index into an on-block colour table.

The colour table has two banks. One bank feeds the pixel path and the other takes host writes, so the host can rebuild a palette without visible tearing. When swapping is enabled, the two banks exchange roles on a vertical-retrace strobe.

Every format passes through the same single output register, so the latency does not depend on the format. The format selector must be held steady while pixels are in flight. The host changes it only after the stream has drained, on a whole-pixel boundary.

Top module: `pixel_colour_proc`

## Requirements
- R1: A word transfers on a clock edge where `word_valid_i` and `word_ready_o` are both high. A pixel transfers where `pix_valid_o` and `pix_ready_i` are both high. While `pix_valid_o` is high and `pix_ready_i` is low, `pix_valid_o` and `pix_rgb_o` hold their values.
- R2: `word_ready_o` is high exactly when at most four bytes are buffered. With the output stalled, format 0 accepts exactly three words and format 3 accepts exactly two words before `word_ready_o` drops.
- R3: Format code 0, and the unused codes 5 to 7, give one pixel per word. Word bits [23:16], [15:8] and [7:0] become R, G and B. Bits [31:24] are ignored.
- R4: Format code 1 treats the words as a byte stream, most significant byte of each word first. Every three consecutive bytes form R, G, B, so three words give four pixels.
- R5: Format code 2 gives two pixels per word, bits [31:16] first. Each pixel has R in [15:11], G in [10:5] and B in [4:0]. Each channel is widened to 8 bits by copying its top bits into the vacated low bits.
- R6: Format code 3 gives four pixels per word, byte [31:24] first, and copies each byte onto R, G and B.
- R7: Format code 4 gives four pixels per word, byte [31:24] first. Each byte indexes the active colour-table bank, and the 24-bit entry (R in [23:16]) is the output.
- R8: A table write (`tbl_we_i`, `tbl_addr_i`, `tbl_data_i`) always lands in the bank that is inactive at that clock edge. This holds even on an edge where the banks swap, and a write never alters the active bank's output.
- R9: The active bank toggles on an edge where `vretrace_i` and `swap_en_i` are both high. Otherwise it keeps its value.
- R10: When the block is empty, the first pixel of an accepted word is valid on the output two clock edges after the acceptance edge, in every format.
- R11: While `rst_n` is low, and for two edges after it rises, `pix_valid_o` and `word_ready_o` are low. After that, the block is empty, bank 0 is active and `word_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| mode_i | input | 3 | Pixel format code |
| swap_en_i | input | 1 | Enables bank exchange on retrace |
| vretrace_i | input | 1 | Vertical-retrace strobe |
| tbl_we_i | input | 1 | Colour-table write strobe |
| tbl_addr_i | input | 8 | Colour-table write index |
| tbl_data_i | input | 24 | Colour-table write data, RGB888 |
| word_valid_i | input | 1 | Pixel word valid |
| word_data_i | input | 32 | Pixel word |
| word_ready_o | output | 1 | Block can take a word |
| pix_valid_o | output | 1 | RGB pixel valid |
| pix_rgb_o | output | 24 | RGB pixel, R in [23:16] |
| pix_ready_i | input | 1 | Sink takes the pixel |

## Verification
Some properties are checked on every cycle by assertions:
- the output holds steady during a stall;
- grey pixels have equal channels;
- 5-6-5 pixels show the bit replication;
- the output becomes valid two edges after a word is accepted;
- the block stays quiet while in reset.

Other behaviour can only be shown by the bench's scenarios, because it depends on data history that a simple property cannot track:
- byte order across words in packed 24-bit format;
- which bank a write lands in, including a write and a swap on the same edge;
- whether a retrace with swapping disabled leaves the palette alone;
- the exact number of words taken under backpressure.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int RGB_W      = 24;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int BUF_BYTES  = 2 * WORD_BYTES;
  localparam int BUF_W      = BUF_BYTES * BYTE_W;
  localparam int CNT_W      = $clog2(BUF_BYTES + 1);

  typedef enum logic [2:0] {
    FMT_XRGB32 = 3'd0,
    FMT_RGB24  = 3'd1,
    FMT_RGB565 = 3'd2,
    FMT_GREY8  = 3'd3,
    FMT_PAL8   = 3'd4
  } pix_fmt_e;

  // bytes of the input stream consumed by one pixel of the given format
  function automatic logic [2:0] fmt_bytes(logic [2:0] fmt);
    case (fmt)
      FMT_RGB24:            fmt_bytes = 3'd3;
      FMT_RGB565:           fmt_bytes = 3'd2;
      FMT_GREY8, FMT_PAL8:  fmt_bytes = 3'd1;
      default:              fmt_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pcp_unpack.sv
module pcp_unpack
  import pcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  input  logic              take_i,
  output logic              avail_o,
  output logic [WORD_W-1:0] raw_o
);

  logic [BUF_W-1:0] byte_q, byte_d, byte_mid;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;
  logic [CNT_W-1:0] step;
  logic             pop, push;

  assign step         = CNT_W'(fmt_bytes(mode_i));
  assign avail_o      = (cnt_q >= step);
  assign word_ready_o = rst_n && (cnt_q <= CNT_W'(WORD_BYTES));
  assign raw_o        = byte_q[BUF_W-1 -: WORD_W];
  assign pop          = avail_o && take_i;
  assign push         = word_valid_i && word_ready_o;

  // bytes are kept left-aligned; positions at or beyond cnt_q are zero
  always_comb begin
    byte_mid = pop ? (byte_q << (BYTE_W * step)) : byte_q;
    cnt_mid  = pop ? (cnt_q - step) : cnt_q;
    byte_d   = byte_mid;
    cnt_d    = cnt_mid;
    if (push) begin
      byte_d = byte_mid | ({word_data_i, {WORD_W{1'b0}}} >> (BYTE_W * cnt_mid));
      cnt_d  = cnt_mid + CNT_W'(WORD_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      cnt_q  <= '0;
    end else if (pop || push) begin
      byte_q <= byte_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/pcp_expand.sv
module pcp_expand
  import pcp_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] raw_i,
  output logic [RGB_W-1:0]  rgb_o
);

  logic [4:0] r5, b5;
  logic [5:0] g6;
  logic [7:0] lead;

  assign r5   = raw_i[31:27];
  assign g6   = raw_i[26:21];
  assign b5   = raw_i[20:16];
  assign lead = raw_i[31:24];

  always_comb begin
    case (mode_i)
      FMT_RGB24:           rgb_o = raw_i[31:8];
      FMT_RGB565:          rgb_o = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
      FMT_GREY8, FMT_PAL8: rgb_o = {lead, lead, lead};
      default:             rgb_o = raw_i[23:0];
    endcase
  end

endmodule

// File: rtl/pcp_lut.sv
module pcp_lut #(
  parameter int DEPTH = 256,
  parameter int W     = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  localparam int NBANK = 2;

  logic                      act_q, act_d;
  logic [NBANK-1:0][W-1:0]   bank_rd;

  assign act_d   = swap_i ? ~act_q : act_q;
  assign rdata_o = bank_rd[act_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [W-1:0] mem_q [DEPTH];
    logic         wr_en;
    assign wr_en = we_i && (act_q != 1'(b));
    always_ff @(posedge clk) begin
      if (wr_en) mem_q[waddr_i] <= wdata_i;
    end
    assign bank_rd[b] = mem_q[raddr_i];
  end

endmodule

// File: rtl/pixel_colour_proc.sv
module pixel_colour_proc
  import pcp_pkg::*;
#(
  parameter int TBL_DEPTH = 256,
  localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              swap_en_i,
  input  logic              vretrace_i,
  input  logic              tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  logic [RGB_W-1:0]  tbl_data_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  output logic [RGB_W-1:0]  pix_rgb_o,
  input  logic              pix_ready_i
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              out_en, avail;
  logic [WORD_W-1:0] raw;
  logic [RGB_W-1:0]  exp_rgb, tbl_rgb, rgb_d, rgb_q;
  logic              vld_d, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pcp_unpack u_unpack (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .mode_i       (mode_i),
    .word_valid_i (word_valid_i),
    .word_data_i  (word_data_i),
    .word_ready_o (word_ready_o),
    .take_i       (out_en),
    .avail_o      (avail),
    .raw_o        (raw)
  );

  pcp_expand u_expand (
    .mode_i (mode_i),
    .raw_i  (raw),
    .rgb_o  (exp_rgb)
  );

  pcp_lut #(.DEPTH(TBL_DEPTH), .W(RGB_W)) u_lut (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .swap_i  (vretrace_i && swap_en_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (raw[WORD_W-1 -: TBL_AW]),
    .rdata_o (tbl_rgb)
  );

  // one output register shared by every format; the table read lands here too
  always_comb begin
    out_en = !vld_q || pix_ready_i;
    vld_d  = out_en ? avail : vld_q;
    rgb_d  = (mode_i == FMT_PAL8) ? tbl_rgb : exp_rgb;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      rgb_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (out_en && avail) rgb_q <= rgb_d;
    end
  end

  assign pix_valid_o = vld_q;
  assign pix_rgb_o   = rgb_q;

endmodule

// File: rtl/pcp_checker.sv
module pcp_checker
  import pcp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic              word_valid_i,
  input logic              word_ready_o,
  input logic              pix_valid_o,
  input logic [RGB_W-1:0]  pix_rgb_o,
  input logic              pix_ready_i
);

  p_hold_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_ready_i) |=> pix_valid_o);

  p_hold_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_ready_i) |=> $stable(pix_rgb_o));

  p_replicate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && mode_i == FMT_RGB565 && $stable(mode_i)) |->
      (pix_rgb_o[18:16] == pix_rgb_o[23:21] && pix_rgb_o[9:8] == pix_rgb_o[15:14]
       && pix_rgb_o[2:0] == pix_rgb_o[7:5]));

  p_grey_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && mode_i == FMT_GREY8 && $stable(mode_i)) |->
      (pix_rgb_o[23:16] == pix_rgb_o[15:8] && pix_rgb_o[15:8] == pix_rgb_o[7:0]));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && word_ready_o) |-> ##2 pix_valid_o);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r11: assert (!pix_valid_o && !word_ready_o);
    end
  end

endmodule

bind pixel_colour_proc pcp_checker u_pcp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .pix_valid_o  (pix_valid_o),
  .pix_rgb_o    (pix_rgb_o),
  .pix_ready_i  (pix_ready_i)
);

// File: tb/pixel_colour_proc_bench.sv
`timescale 1ns/1ps
module pixel_colour_proc_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        swap_en, vretrace, tbl_we;
  logic [7:0]  tbl_addr;
  logic [23:0] tbl_data;
  logic        word_valid, word_ready, pix_valid, pix_ready;
  logic [31:0] word_data;
  logic [23:0] pix_rgb;

  int total = 0;
  int bad   = 0;
  int acc_cnt;
  bit hold_rdy;
  bit prev_stall;
  logic [23:0] prev_rgb;
  string tag;

  logic [31:0] wq[$];
  logic [23:0] exp_q[$];
  logic [7:0]  bq[$];
  logic [23:0] lut_m [2][256];
  int act_m;

  always #5 clk = ~clk;

  pixel_colour_proc u_pixel_colour_proc (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .swap_en_i(swap_en),
    .vretrace_i(vretrace), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_data_i(tbl_data), .word_valid_i(word_valid), .word_data_i(word_data),
    .word_ready_o(word_ready), .pix_valid_o(pix_valid), .pix_rgb_o(pix_rgb),
    .pix_ready_i(pix_ready)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bpp_of(logic [2:0] m);
    case (m)
      3'd1: return 3;
      3'd2: return 2;
      3'd3, 3'd4: return 1;
      default: return 4;
    endcase
  endfunction

  function automatic logic [23:0] model_pix(logic [2:0] m, logic [31:0] raw);
    case (m)
      3'd1: return raw[31:8];
      3'd2: return {raw[31:27], raw[31:29], raw[26:21], raw[26:25], raw[20:16], raw[20:18]};
      3'd3: return {raw[31:24], raw[31:24], raw[31:24]};
      3'd4: return lut_m[act_m][raw[31:24]];
      default: return raw[23:0];
    endcase
  endfunction

  task automatic push_word(logic [31:0] w);
    logic [31:0] raw;
    wq.push_back(w);
    for (int k = 3; k >= 0; k--) bq.push_back(w[8*k +: 8]);
    while (bq.size() >= bpp_of(mode)) begin
      raw = '0;
      for (int j = 0; j < bpp_of(mode); j++) raw[31-8*j -: 8] = bq.pop_front();
      exp_q.push_back(model_pix(mode, raw));
    end
  endtask

  task automatic step();
    logic [23:0] e;
    @(negedge clk);
    word_valid = (wq.size() > 0) && ($urandom_range(3) != 0);
    word_data  = (wq.size() > 0) ? wq[0] : 32'h0;
    pix_ready  = !hold_rdy && ($urandom_range(3) != 0);
    #1;
    if (prev_stall) check(pix_valid && pix_rgb == prev_rgb, "R1", {8'h0, pix_rgb}, {8'h0, prev_rgb});
    if (word_valid && word_ready) begin
      void'(wq.pop_front());
      acc_cnt++;
    end
    if (pix_valid && pix_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R1", {8'h0, pix_rgb}, 32'h0);
      else begin
        e = exp_q.pop_front();
        check(pix_rgb == e, tag, {8'h0, pix_rgb}, {8'h0, e});
      end
    end
    prev_stall = pix_valid && !pix_ready;
    prev_rgb   = pix_rgb;
  endtask

  task automatic drain();
    prev_stall = 1'b0;
    for (int i = 0; i < 4000 && (wq.size() > 0 || exp_q.size() > 0); i++) step();
    for (int i = 0; i < 4; i++) step();
    check(exp_q.size() == 0 && wq.size() == 0 && bq.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic run(string t, logic [2:0] m, int n);
    @(negedge clk);
    tag  = t;
    mode = m;
    for (int i = 0; i < n; i++) push_word($urandom());
    drain();
  endtask

  task automatic tbl_write(logic [7:0] a, logic [23:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    lut_m[1-act_m][a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic retrace(bit en);
    @(negedge clk);
    vretrace = 1'b1; swap_en = en;
    @(negedge clk);
    vretrace = 1'b0; swap_en = 1'b0;
    if (en) act_m = 1 - act_m;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mode = 3'd0; swap_en = 0; vretrace = 0; tbl_we = 0; tbl_addr = '0; tbl_data = '0;
    word_valid = 0; word_data = '0; pix_ready = 0; hold_rdy = 0; act_m = 0;
    prev_stall = 0; acc_cnt = 0; tag = "R1";
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(!pix_valid && !word_ready, "R11", {pix_valid, word_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check(!pix_valid && word_ready, "R11", {pix_valid, word_ready}, 1);

    // R10 and R3: one word, fixed latency, top byte dropped
    @(negedge clk);
    mode = 3'd0; pix_ready = 1'b1; word_valid = 1'b1; word_data = 32'hAA112233;
    @(negedge clk);
    word_valid = 1'b0;
    #1 check(!pix_valid, "R10", pix_valid, 0);
    @(negedge clk);
    #1 check(pix_valid && pix_rgb == 24'h112233, "R10", {8'h0, pix_rgb}, 32'h112233);
    @(negedge clk);
    // R10 in 16-bit format: upper half first
    mode = 3'd2; word_valid = 1'b1; word_data = 32'h0000FFFF;
    @(negedge clk);
    word_valid = 1'b0;
    @(negedge clk);
    #1 check(pix_valid && pix_rgb == 24'h000000, "R10", {8'h0, pix_rgb}, 32'h0);
    @(negedge clk);
    #1 check(pix_valid && pix_rgb == 24'hFFFFFF, "R5", {8'h0, pix_rgb}, 32'hFFFFFF);
    repeat (2) @(negedge clk);

    // fill both table banks (R8, R9)
    for (int i = 0; i < 256; i++) tbl_write(8'(i), 24'($urandom()));
    retrace(1'b1);
    for (int i = 0; i < 256; i++) tbl_write(8'(i), 24'($urandom()));

    run("R3", 3'd0, 40);
    run("R4", 3'd1, 42);
    run("R5", 3'd2, 40);
    run("R6", 3'd3, 40);
    run("R7", 3'd4, 40);
    run("R3", 3'd7, 12);

    // R2: backpressure, 32-bit format
    @(negedge clk);
    tag = "R3"; mode = 3'd0; hold_rdy = 1'b1; acc_cnt = 0;
    for (int i = 0; i < 5; i++) push_word($urandom());
    for (int i = 0; i < 14; i++) step();
    check(acc_cnt == 3 && !word_ready, "R2", acc_cnt, 3);
    hold_rdy = 1'b0;
    drain();

    // R2: backpressure, 8-bit grey format
    @(negedge clk);
    tag = "R6"; mode = 3'd3; hold_rdy = 1'b1; acc_cnt = 0;
    for (int i = 0; i < 4; i++) push_word($urandom());
    for (int i = 0; i < 14; i++) step();
    check(acc_cnt == 2 && !word_ready, "R2", acc_cnt, 2);
    hold_rdy = 1'b0;
    drain();

    // R8: write to the hidden bank leaves the visible palette alone
    tbl_write(8'h5A, 24'hABCDEF);
    check(lut_m[act_m][8'h5A] != 24'hABCDEF, "R8", lut_m[act_m][8'h5A], 0);
    @(negedge clk);
    tag = "R8"; mode = 3'd4;
    for (int i = 0; i < 3; i++) push_word(32'h5A5A5A5A);
    drain();
    // R9: retrace with swapping disabled changes nothing
    retrace(1'b0);
    tag = "R9";
    for (int i = 0; i < 2; i++) push_word(32'h5A5A5A5A);
    drain();
    // R9: retrace with swapping enabled exposes the new entry
    retrace(1'b1);
    tag = "R9";
    push_word(32'h5A5A5A5A);
    check(exp_q[0] == 24'hABCDEF, "R9", exp_q[0], 32'hABCDEF);
    drain();
    // R8: write and swap on the same edge go to the bank that becomes active
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'h33; tbl_data = 24'h13579B;
    vretrace = 1'b1; swap_en = 1'b1;
    lut_m[1-act_m][8'h33] = 24'h13579B;
    act_m = 1 - act_m;
    @(negedge clk);
    tbl_we = 1'b0; vretrace = 1'b0; swap_en = 1'b0;
    tag = "R8";
    push_word(32'h33333333);
    check(exp_q[0] == 24'h13579B, "R8", exp_q[0], 32'h13579B);
    drain();

    run("R4", 3'd1, 30);
    run("R7", 3'd4, 24);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule